// File: doc/BRIEF.md
# Interrupt and Exception Entry Sequencer

This block carries a core from "an interrupt or fault has been raised" to "the handler is about to run". On a start pulse it captures the core's architectural state, reads the gate for the vector over a single memory port, switches to an inner stack when the handler runs at a more privileged level, writes the return frame, and reports the new CS, instruction pointer, flags, SS, stack pointer and privilege level with a one-cycle done pulse. In real mode the vector is a four-byte far pointer that is turned into a 16-bit interrupt gate. In protected mode the vector is an eight-byte gate.

The block keeps count of faults that nest. A memory error on any fetch or push abandons the current attempt and starts a new fault. When a fault is raised while another is still in progress, it is dispatched through the double-fault vector. When a third fault is raised, the block gives up and pulses a core reset instead of dispatching.

The state machine has fifteen states:
- IDLE waits for start.
- RAISE counts a fault and picks the vector.
- GATE_LO and GATE_HI read the gate.
- EVAL decides whether the stack changes.
- TSS_SP and TSS_SS read the inner stack pointer and stack selector.
- PUSH_SS, PUSH_SP, PUSH_FL, PUSH_CS, PUSH_IP and PUSH_EC each write one frame item.
- DONE publishes the results.
- RESET signals the escalation to a core reset.

The transitions are:
- IDLE goes to RAISE on a fault and to GATE_LO on a software interrupt.
- RAISE goes to RESET on the third fault and to GATE_LO otherwise.
- GATE_LO goes to GATE_HI in protected mode and to EVAL in real mode.
- GATE_HI goes to EVAL.
- EVAL goes to TSS_SP on a privilege change and to PUSH_FL otherwise.
- TSS_SP goes to TSS_SS, and TSS_SS goes to PUSH_SS.
- The pushes run in the order PUSH_SS, PUSH_SP, PUSH_FL, PUSH_CS, PUSH_IP.
- PUSH_IP goes to PUSH_EC or to DONE.
- PUSH_EC goes to DONE.
- Any access that ends with a memory error goes back to RAISE.
- DONE and RESET return to IDLE.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, busy, done, core_reset and mem_req are all low.
- R2: Memory handshake and status:
  - start is taken only in IDLE.
  - busy is high from the cycle after start until the sequence ends.
  - done pulses for exactly one cycle while busy is low.
  - A request holds mem_addr steady until mem_ack.
- R3: In real mode (prot_mode=0), the vector entry is one 32-bit read at vec_base + 4·vector. Bits [15:0] of that word give the handler offset and bits [31:16] give the selector. The entry is treated as a present 16-bit interrupt gate with privilege 0.
- R4: In protected mode, the gate is read as two 32-bit words at vec_base + 8·vector and +4.
  - The first word holds the offset in [15:0] and the selector in [31:16].
  - The second word holds the gate type in [11:8] and offset bits 31:16 in [31:16].
  - Type 6h is a 16-bit interrupt gate, 7h a 16-bit trap gate, Eh a 32-bit interrupt gate and Fh a 32-bit trap gate.
- R5: In protected mode, when the selector RPL (bits [1:0]) is below cpl:
  - The new stack pointer is read from tss_base + 4 + 8·RPL.
  - The new SS is read from tss_base + 8 + 8·RPL.
  - The old SS, then the old stack pointer, are pushed on the new stack.
  - new_cpl becomes the RPL.
  - Without a privilege change, the stack and cpl are kept.
- R6: The frame is pushed in the order flags, CS, instruction pointer, error code. The error code is pushed only for a fault with err_valid set in protected mode.
- R7: Push width and stack writes:
  - Pushes are 16 bits in real mode.
  - In protected mode, pushes are 32 bits for a 32-bit gate (type bit 3 set) and 16 bits otherwise.
  - Before each write, the stack pointer drops by the push width, and the write goes to the new stack pointer.
- R8: Interrupt gates (type bit 0 clear, including the real-mode gate) clear flag bit 9 (IF) in new_flags. Trap gates leave the flags unchanged. The pushed flags are always the original ones.
- R9: A fault pushes saved_ip (the faulting instruction). A software interrupt pushes cur_ip.
- R10: new_ip depends on the gate size:
  - A 32-bit gate loads the full 32-bit offset.
  - A 16-bit gate replaces only bits [15:0] of the pushed instruction pointer.
- R11: A memory error on any fetch or push aborts the attempt.
  - The stack and privilege level return to their captured values.
  - The attempt re-enters as a fault with vector 13 and error code 0.
  - Each fault raised increments a counter. When the count exceeds 1, the vector becomes 8 with error code 0.
- R12: A fault that brings the counter to 3 pulses core_reset without done and clears the counter. A completed dispatch also clears the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a dispatch (taken in IDLE) |
| is_fault | input | 1 | 1 = exception, 0 = software interrupt |
| vec | input | 8 | Vector number |
| err_valid | input | 1 | Exception carries an error code |
| err_code | input | 32 | Error code value |
| prot_mode | input | 1 | Protected mode active |
| cpl | input | 2 | Current privilege level |
| cur_cs | input | 16 | Current code selector |
| cur_ip | input | 32 | Address of next instruction |
| saved_ip | input | 32 | Address of faulting instruction |
| cur_flags | input | 32 | Current flags |
| cur_ss | input | 16 | Current stack selector |
| cur_sp | input | 32 | Current stack pointer |
| vec_base | input | 32 | Vector/gate table base |
| tss_base | input | 32 | Task-state record base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write access |
| mem_wide | output | 1 | 1 = 32-bit access, 0 = 16-bit |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed (with mem_ack) |
| mem_rdata | input | 32 | Read data (with mem_ack) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Dispatch completed, results valid |
| core_reset | output | 1 | Third fault, reset the core |
| new_cs | output | 16 | Handler code selector |
| new_ip | output | 32 | Handler instruction pointer |
| new_flags | output | 32 | Flags for the handler |
| new_ss | output | 16 | Stack selector after entry |
| new_sp | output | 32 | Stack pointer after the frame |
| new_cpl | output | 2 | Privilege level after entry |

## Verification
The bench builds the block with its default parameters: an 8-bit vector, a 2-bit fault counter, double-fault vector 8, abort vector 13 and a reset at the third fault. With these values, the whole escalation chain is reachable with at most two injected memory errors.

The protected-mode sweep runs all four gate types against every pairing of current privilege and target RPL. This covers every push width and every stack-switch case, with the error-code push toggled along the way. A second sweep runs all 32 real-mode vectors.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    localparam int WORD_W = 32;
    localparam int SEL_W  = 16;
    localparam int IF_BIT = 9;

    typedef enum logic [3:0] {
        S_IDLE, S_RAISE, S_GATE_LO, S_GATE_HI, S_EVAL,
        S_TSS_SP, S_TSS_SS,
        S_PUSH_SS, S_PUSH_SP, S_PUSH_FL, S_PUSH_CS, S_PUSH_IP, S_PUSH_EC,
        S_DONE, S_RESET
    } seq_state_t;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [WORD_W-1:0] off;
        logic              wide;
        logic              intr;
    } gate_t;
endpackage

// File: rtl/irq_gate_decode.sv
module irq_gate_decode
    import irq_seq_pkg::*;
(
    input  logic [WORD_W-1:0] word_lo,
    input  logic [WORD_W-1:0] word_hi,
    input  logic              prot,
    output gate_t             gate
);
    always_comb begin
        gate.sel = word_lo[WORD_W-1:16];
        if (prot) begin
            gate.off  = {word_hi[WORD_W-1:16], word_lo[15:0]};
            gate.wide = word_hi[11];
            gate.intr = ~word_hi[8];
        end else begin
            // real-mode pointer behaves as a 16-bit interrupt gate
            gate.off  = {{(WORD_W-16){1'b0}}, word_lo[15:0]};
            gate.wide = 1'b0;
            gate.intr = 1'b1;
        end
    end
endmodule

// File: rtl/irq_fault_tracker.sv
module irq_fault_tracker #(
    parameter int CNT_W      = 2,
    parameter int VEC_W      = 8,
    parameter int DF_VEC     = 8,
    parameter int TRIPLE_CNT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raise,
    input  logic             clear,
    input  logic [VEC_W-1:0] vec_in,
    output logic [VEC_W-1:0] vec_out,
    output logic             escalated,
    output logic             triple,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TRIP = CNT_W'(TRIPLE_CNT);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc   = count + ONE;
        escalated = cnt_inc > ONE;
        triple    = cnt_inc == TRIP;
        vec_out   = escalated ? VEC_W'(DF_VEC) : vec_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) count <= '0;
        else if (raise)      count <= triple ? '0 : cnt_inc;
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int VEC_W      = 8,
    parameter int CNT_W      = 2,
    parameter int DF_VEC     = 8,
    parameter int ABORT_VEC  = 13,
    parameter int TRIPLE_CNT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_fault,
    input  logic [VEC_W-1:0]  vec,
    input  logic              err_valid,
    input  logic [WORD_W-1:0] err_code,
    input  logic              prot_mode,
    input  logic [1:0]        cpl,
    input  logic [SEL_W-1:0]  cur_cs,
    input  logic [WORD_W-1:0] cur_ip,
    input  logic [WORD_W-1:0] saved_ip,
    input  logic [WORD_W-1:0] cur_flags,
    input  logic [SEL_W-1:0]  cur_ss,
    input  logic [WORD_W-1:0] cur_sp,
    input  logic [WORD_W-1:0] vec_base,
    input  logic [WORD_W-1:0] tss_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              core_reset,
    output logic [SEL_W-1:0]  new_cs,
    output logic [WORD_W-1:0] new_ip,
    output logic [WORD_W-1:0] new_flags,
    output logic [SEL_W-1:0]  new_ss,
    output logic [WORD_W-1:0] new_sp,
    output logic [1:0]        new_cpl
);
    localparam int VPAD = WORD_W - VEC_W;
    localparam logic [WORD_W-1:0] IF_MASK = WORD_W'(1) << IF_BIT;

    seq_state_t state, nxt;

    // captured originals and working copies
    logic [SEL_W-1:0]  o_cs, o_ss, w_ss;
    logic [WORD_W-1:0] o_ip, o_flags, o_sp, w_sp;
    logic [1:0]        o_cpl, w_cpl;
    logic [WORD_W-1:0] base_r, tss_r, err_r, g_lo, g_hi;
    logic [VEC_W-1:0]  vec_r;
    logic              pm_r, errv_r, wide_r;

    gate_t             gd;
    logic              tr_raise, tr_clear, tr_esc, tr_triple;
    logic [VEC_W-1:0]  tr_vec;
    logic [CNT_W-1:0]  tr_count;

    logic [WORD_W-1:0] vec_off, push_addr, slot_addr;
    logic              acc_ok, acc_bad;

    irq_gate_decode u_dec (.word_lo(g_lo), .word_hi(g_hi), .prot(pm_r), .gate(gd));

    irq_fault_tracker #(
        .CNT_W(CNT_W), .VEC_W(VEC_W), .DF_VEC(DF_VEC), .TRIPLE_CNT(TRIPLE_CNT)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .raise(tr_raise), .clear(tr_clear),
        .vec_in(vec_r), .vec_out(tr_vec), .escalated(tr_esc),
        .triple(tr_triple), .count(tr_count)
    );

    always_comb begin
        vec_off   = pm_r ? {{(VPAD-3){1'b0}}, vec_r, 3'b000}
                         : {{(VPAD-2){1'b0}}, vec_r, 2'b00};
        push_addr = w_sp - (wide_r ? WORD_W'(4) : WORD_W'(2));
        slot_addr = tss_r + WORD_W'(4) + {{(WORD_W-5){1'b0}}, gd.sel[1:0], 3'b000};
        acc_ok    = mem_ack && !mem_err;
        acc_bad   = mem_ack && mem_err;
        busy      = state != S_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state and memory port
    always_comb begin
        nxt       = state;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wide  = 1'b1;
        mem_addr  = '0;
        mem_wdata = '0;
        tr_raise  = 1'b0;
        tr_clear  = 1'b0;
        unique case (state)
            S_IDLE:    if (start) nxt = is_fault ? S_RAISE : S_GATE_LO;
            S_RAISE: begin
                tr_raise = 1'b1;
                nxt = tr_triple ? S_RESET : S_GATE_LO;
            end
            S_GATE_LO: begin
                mem_req  = 1'b1;
                mem_addr = base_r + vec_off;
                if (acc_ok) nxt = pm_r ? S_GATE_HI : S_EVAL;
            end
            S_GATE_HI: begin
                mem_req  = 1'b1;
                mem_addr = base_r + vec_off + WORD_W'(4);
                if (acc_ok) nxt = S_EVAL;
            end
            S_EVAL:    nxt = (pm_r && (gd.sel[1:0] < w_cpl)) ? S_TSS_SP : S_PUSH_FL;
            S_TSS_SP: begin
                mem_req  = 1'b1;
                mem_addr = slot_addr;
                if (acc_ok) nxt = S_TSS_SS;
            end
            S_TSS_SS: begin
                mem_req  = 1'b1;
                mem_addr = slot_addr + WORD_W'(4);
                if (acc_ok) nxt = S_PUSH_SS;
            end
            S_PUSH_SS, S_PUSH_SP, S_PUSH_FL, S_PUSH_CS, S_PUSH_IP, S_PUSH_EC: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_wide = wide_r;
                mem_addr = push_addr;
                unique case (state)
                    S_PUSH_SS: begin mem_wdata = {{(WORD_W-SEL_W){1'b0}}, o_ss}; if (acc_ok) nxt = S_PUSH_SP; end
                    S_PUSH_SP: begin mem_wdata = o_sp;    if (acc_ok) nxt = S_PUSH_FL; end
                    S_PUSH_FL: begin mem_wdata = o_flags; if (acc_ok) nxt = S_PUSH_CS; end
                    S_PUSH_CS: begin mem_wdata = {{(WORD_W-SEL_W){1'b0}}, o_cs}; if (acc_ok) nxt = S_PUSH_IP; end
                    S_PUSH_IP: begin
                        mem_wdata = o_ip;
                        if (acc_ok) nxt = (errv_r && pm_r) ? S_PUSH_EC : S_DONE;
                    end
                    default:   begin mem_wdata = err_r;   if (acc_ok) nxt = S_DONE; end
                endcase
            end
            S_DONE: begin
                tr_clear = 1'b1;
                nxt = S_IDLE;
            end
            S_RESET:   nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
        if (mem_req && acc_bad) nxt = S_RAISE;
    end

    // working datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_r   <= 1'b0;
            wide_r <= 1'b0;
            errv_r <= 1'b0;
        end else begin
            if (state == S_IDLE && start) begin
                o_cs    <= cur_cs;
                o_ss    <= cur_ss;
                o_sp    <= cur_sp;
                o_flags <= cur_flags;
                o_cpl   <= cpl;
                o_ip    <= is_fault ? saved_ip : cur_ip;
                w_ss    <= cur_ss;
                w_sp    <= cur_sp;
                w_cpl   <= cpl;
                pm_r    <= prot_mode;
                base_r  <= vec_base;
                tss_r   <= tss_base;
                vec_r   <= vec;
                errv_r  <= is_fault && err_valid;
                err_r   <= err_code;
                wide_r  <= 1'b0;
            end
            if (state == S_RAISE) begin
                vec_r <= tr_vec;
                w_sp  <= o_sp;
                w_ss  <= o_ss;
                w_cpl <= o_cpl;
                if (tr_esc) begin
                    errv_r <= 1'b1;
                    err_r  <= '0;
                end
            end
            if (mem_req && acc_bad) begin
                vec_r  <= VEC_W'(ABORT_VEC);
                errv_r <= 1'b1;
                err_r  <= '0;
            end
            if (acc_ok) begin
                unique case (state)
                    S_GATE_LO: g_lo <= mem_rdata;
                    S_GATE_HI: g_hi <= mem_rdata;
                    S_TSS_SP:  w_sp <= mem_rdata;
                    S_TSS_SS:  w_ss <= mem_rdata[SEL_W-1:0];
                    default:   w_sp <= push_addr;
                endcase
            end
            if (state == S_EVAL) begin
                wide_r <= pm_r && gd.wide;
                if (pm_r && (gd.sel[1:0] < w_cpl)) w_cpl <= gd.sel[1:0];
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            core_reset <= 1'b0;
            new_cs     <= '0;
            new_ip     <= '0;
            new_flags  <= '0;
            new_ss     <= '0;
            new_sp     <= '0;
            new_cpl    <= '0;
        end else begin
            done       <= state == S_DONE;
            core_reset <= state == S_RESET;
            if (state == S_DONE) begin
                new_cs    <= gd.sel;
                new_ip    <= gd.wide ? gd.off : {o_ip[WORD_W-1:16], gd.off[15:0]};
                new_flags <= gd.intr ? (o_flags & ~IF_MASK) : o_flags;
                new_ss    <= w_ss;
                new_sp    <= w_sp;
                new_cpl   <= w_cpl;
            end
        end
    end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int CNT_W      = 2,
    parameter int TRIPLE_CNT = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             core_reset,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_wide,
    input logic [31:0]      mem_addr,
    input logic             mem_ack,
    input logic             pm_r,
    input logic [CNT_W-1:0] fault_cnt
);
    a_r2_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r7_real_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !pm_r) |-> !mem_wide);

    a_r12_reset_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset |-> !done);

    a_r12_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault_cnt == '0));

    a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fault_cnt < CNT_W'(TRIPLE_CNT));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.CNT_W(CNT_W), .TRIPLE_CNT(TRIPLE_CNT)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .core_reset(core_reset),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .pm_r(pm_r), .fault_cnt(tr_count)
);

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    logic        clk = 0, rst_n = 0, start = 0, is_fault = 0, err_valid = 0, prot_mode = 0;
    logic [7:0]  vec = 0;
    logic [31:0] err_code = 0, cur_ip = 0, saved_ip = 0, cur_flags = 0, cur_sp = 0;
    logic [31:0] vec_base = 0, tss_base = 0;
    logic [1:0]  cpl = 0;
    logic [15:0] cur_cs = 0, cur_ss = 0;
    logic        mem_req, mem_we, mem_wide, mem_ack = 0, mem_err = 0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
    logic        busy, done, core_reset;
    logic [15:0] new_cs, new_ss;
    logic [31:0] new_ip, new_flags, new_sp;
    logic [1:0]  new_cpl;

    int nchk = 0, nfail = 0;
    int inj_hits = 0, inj_lim = 0;
    logic [31:0] inj_addr = 32'hFFFF_FFFF;
    logic [7:0] rom [0:2047];
    logic [7:0] stk [0:2047];

    always #2 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (.*);

    function automatic logic [7:0] rdb(logic [31:0] a);
        return a[11] ? stk[a[10:0]] : rom[a[10:0]];
    endfunction
    function automatic logic [31:0] rd32(logic [31:0] a);
        return {rdb(a + 3), rdb(a + 2), rdb(a + 1), rdb(a)};
    endfunction

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        mem_err <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we && inj_hits < inj_lim && mem_addr == inj_addr) begin
                mem_err  <= 1'b1;
                inj_hits <= inj_hits + 1;
            end else if (mem_we) begin
                stk[mem_addr[10:0]]     <= mem_wdata[7:0];
                stk[mem_addr[10:0] + 1] <= mem_wdata[15:8];
                if (mem_wide) begin
                    stk[mem_addr[10:0] + 2] <= mem_wdata[23:16];
                    stk[mem_addr[10:0] + 3] <= mem_wdata[31:24];
                end
            end else begin
                mem_rdata <= rd32(mem_addr);
            end
        end
    end

    task automatic wr_rom(input logic [31:0] a, input logic [31:0] d);
        for (int i = 0; i < 4; i++) rom[a[10:0] + i[10:0]] = d[8*i +: 8];
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic stk_val(input string tag, input logic [31:0] a, input bit wide, input logic [31:0] exp);
        logic [31:0] v;
        v = rd32(a);
        if (!wide) begin
            v   = {16'h0, v[15:0]};
            exp = {16'h0, exp[15:0]};
        end
        chk(tag, v, exp);
    endtask

    task automatic run_seq(output bit got_done, output bit got_rst);
        int n;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        chk("R2 busy after start", {31'b0, busy}, 1);
        n = 0;
        while (!done && !core_reset && n < 3000) begin
            @(negedge clk);
            n++;
        end
        got_done = done;
        got_rst  = core_reset;
        if (n >= 3000) chk("R2 sequence completes", 0, 1);
        @(negedge clk);
        chk("R2 done single cycle", {31'b0, done}, 0);
    endtask

    task automatic set_gate(input int v, input logic [3:0] ty, input logic [15:0] sel, input logic [31:0] off);
        wr_rom(32'(v * 8), {sel, off[15:0]});
        wr_rom(32'(v * 8 + 4), {off[31:16], 4'h8, ty, 8'h00});
    endtask

    initial begin
        #(4 * 200000);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        bit gd, gr;
        for (int i = 0; i < 2048; i++) begin rom[i] = 0; stk[i] = 0; end
        repeat (3) @(negedge clk);
        chk("R1 busy at reset", {31'b0, busy}, 0);
        chk("R1 done at reset", {31'b0, done}, 0);
        chk("R1 core_reset at reset", {31'b0, core_reset}, 0);
        chk("R1 mem_req at reset", {31'b0, mem_req}, 0);
        rst_n = 1;
        @(negedge clk);

        // real-mode sweep: R3, R6, R7, R8, R9, R10
        for (int v = 0; v < 32; v++) begin
            logic [15:0] off, sel;
            logic [31:0] ipx, fl;
            off = 16'h1000 + 16'(v * 17);
            sel = 16'h3000 + 16'(v);
            wr_rom(32'h600 + 32'(v * 4), {sel, off});
            prot_mode = 0; vec_base = 32'h600; vec = 8'(v);
            is_fault = v[0]; err_valid = 1; err_code = 32'h55;
            cur_ip = 32'hABCD_0100 + 32'(v); saved_ip = 32'hABCD_0200 + 32'(v);
            cur_flags = 32'h0000_0200 | 32'(v); cur_cs = 16'h5000 + 16'(v);
            cur_ss = 16'h0030; cur_sp = 32'hF00; cpl = 0;
            ipx = v[0] ? saved_ip : cur_ip;
            fl = cur_flags;
            run_seq(gd, gr);
            chk("R3 real done", {31'b0, gd}, 1);
            chk("R3 real selector", new_cs, sel);
            chk("R10 real ip low half", new_ip, {ipx[31:16], off});
            chk("R8 real IF cleared", new_flags, fl & ~32'h200);
            chk("R7/R6 real sp no error code", new_sp, 32'hEFA);
            chk("R5 real ss kept", new_ss, 16'h0030);
            stk_val("R6 real flags push", 32'hEFE, 0, fl);
            stk_val("R6 real cs push", 32'hEFC, 0, cur_cs);
            stk_val("R9 real ip push", 32'hEFA, 0, ipx);
        end

        // protected sweep: R4, R5, R6, R7, R8, R9, R10
        tss_base = 32'h700; vec_base = 0;
        for (int l = 0; l < 3; l++) begin
            wr_rom(32'h704 + 32'(8 * l), 32'hC00 + 32'(l * 256));
            wr_rom(32'h708 + 32'(8 * l), 32'h10 + 32'(l * 8));
        end
        for (int idx = 0; idx < 64; idx++) begin
            logic [3:0] ty;
            logic [1:0] c, r;
            logic [15:0] sel;
            logic [31:0] off, ipx, p, fl;
            bit wide, sw, intr, ec;
            int w;
            ty = (idx / 16 == 0) ? 4'h6 : (idx / 16 == 1) ? 4'h7 : (idx / 16 == 2) ? 4'hE : 4'hF;
            c = 2'((idx / 4) % 4); r = 2'(idx % 4);
            sel = 16'h0800 + 16'(idx * 8) + 16'(r);
            off = 32'h00A1_0000 + 32'(idx * 32'h0001_0101);
            set_gate(40 + idx, ty, sel, off);
            prot_mode = 1; vec = 8'(40 + idx); cpl = c;
            is_fault = (idx % 2) == 1; err_valid = ((idx / 2) % 2) == 1;
            err_code = 32'hE000_0000 + 32'(idx);
            cur_ip = 32'h1234_0000 + 32'(idx); saved_ip = 32'h5678_0000 + 32'(idx);
            cur_flags = 32'h0000_0A00 + 32'(idx); cur_cs = 16'h0100 + 16'(idx);
            cur_ss = 16'h0040; cur_sp = 32'hF00;
            wide = ty[3]; intr = !ty[0]; sw = r < c;
            ec = is_fault && err_valid;
            w = wide ? 4 : 2;
            ipx = is_fault ? saved_ip : cur_ip;
            fl = cur_flags;
            run_seq(gd, gr);
            chk("R4 prot done", {31'b0, gd}, 1);
            chk("R4 prot selector", new_cs, sel);
            chk("R10 prot ip", new_ip, wide ? off : {ipx[31:16], off[15:0]});
            chk("R8 prot flags", new_flags, intr ? (fl & ~32'h200) : fl);
            chk("R5 prot cpl", {30'b0, new_cpl}, {30'b0, sw ? r : c});
            chk("R5 prot ss", new_ss, sw ? 16'h10 + 16'(r) * 8 : 16'h0040);
            p = sw ? 32'hC00 + 32'(r) * 256 : 32'hF00;
            if (sw) begin
                p = p - w; stk_val("R5 old ss push", p, wide, 32'h0040);
                p = p - w; stk_val("R5 old sp push", p, wide, 32'hF00);
            end
            p = p - w; stk_val("R6 prot flags push", p, wide, fl);
            p = p - w; stk_val("R6 prot cs push", p, wide, cur_cs);
            p = p - w; stk_val("R9 prot ip push", p, wide, ipx);
            if (ec) begin
                p = p - w; stk_val("R6 prot error code push", p, wide, err_code);
            end
            chk("R7 prot final sp", new_sp, p);
        end

        // escalation: R11, R12
        set_gate(8, 4'hE, 16'h0DF8, 32'h0008_0800);
        set_gate(13, 4'hF, 16'h0D08, 32'h000D_0D00);
        set_gate(14, 4'hE, 16'h0E08, 32'h0014_1400);
        prot_mode = 1; vec = 14; cpl = 0; cur_sp = 32'hF00; cur_flags = 32'h0000_0202;
        cur_ip = 32'h0000_3000; saved_ip = 32'h0000_2FF0; err_valid = 1; err_code = 32'h77;
        inj_addr = 32'hEFC;

        for (int k = 0; k < 2; k++) begin
            is_fault = 1;
            inj_lim = inj_hits + 1;
            run_seq(gd, gr);
            chk("R11 fault plus error gives double fault", new_cs, 16'h0DF8);
            chk("R12 repeated double fault still dispatches", {31'b0, gd}, 1);
            chk("R11 double fault ip", new_ip, 32'h0008_0800);
            chk("R11 double fault sp", new_sp, 32'hEF0);
            stk_val("R11 double fault error code 0", 32'hEF0, 1, 0);
            stk_val("R9 double fault keeps saved ip", 32'hEF4, 1, saved_ip);
        end

        is_fault = 0;
        inj_lim = inj_hits + 1;
        run_seq(gd, gr);
        chk("R11 interrupt plus error gives vector 13", new_cs, 16'h0D08);
        chk("R11 vector 13 trap keeps IF", new_flags, 32'h0000_0202);
        stk_val("R11 vector 13 error code 0", 32'hEF0, 1, 0);
        stk_val("R9 interrupt pushes cur ip", 32'hEF4, 1, cur_ip);

        is_fault = 1;
        inj_lim = inj_hits + 2;
        run_seq(gd, gr);
        chk("R12 third fault resets core", {31'b0, gr}, 1);
        chk("R12 third fault no done", {31'b0, gd}, 0);

        inj_lim = inj_hits;
        run_seq(gd, gr);
        chk("R12 counter cleared after reset", new_cs, 16'h0E08);
        stk_val("R6 error code pushed after clear", 32'hEF0, 1, 32'h77);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule